// File: doc/BRIEF.md
# Banked Data-Memory Address Mapper

This block translates every data-memory access of a small processor core into a location in a 512-entry register file that is split into four 128-entry banks. A direct access carries a 7-bit offset from the instruction and a 2-bit bank select. Offset 00h in any bank is not storage. It is an alias that redirects the access through a pointer: the 9-bit target address is the indirect bank bit placed above the 8-bit pointer register.

Some locations are shared by all banks. The top sixteen offsets of every bank fold onto bank 0. A handful of core registers also sit at fixed offsets, with one instance in bank 0: the pointer, status, program-counter low byte, program-counter latch and interrupt control. Locations with no storage behind them read as zero, and writes to them are dropped and flagged.

The mapper is combinational from its inputs to its outputs. Its only state is the pointer register, which it holds itself. The pointer loads whenever a write resolves to its bank-0 location.

Top module: `bank_map_top`

## Requirements
- R1: A read with offset 01h–6Fh that is neither a core offset nor a hole gives `phys_addr_o` = {bank_i, ofs_i} and `valid_o`=1, in the same cycle.
- R2: When `ofs_i` is 00h, the target address is {ind_bank_i, ptr_o}, and `bank_i` is ignored. This target then follows every other rule.
- R3: If the target's low 7 bits are 0 (000h, 080h, 100h or 180h), the result is `rd_zero_o`=1 and `valid_o`=0. It also gives `wr_en_o`=0, `wr_drop_o`=0 and `phys_addr_o`=0.
- R4: A target offset of 70h–7Fh in any bank maps to 070h–07Fh.
- R5: Target offsets 02h, 03h, 04h, 0Ah and 0Bh map to 002h, 003h, 004h, 00Ah and 00Bh in every bank.
- R6: The holes are 00Dh, 018h–01Dh, 08Dh, 08Fh–09Eh, 105h, 109h, 10Ch, 185h, 189h and 18Ch–19Fh. A read of a hole gives `valid_o`=0, `rd_zero_o`=1 and `phys_addr_o`=0.
- R7: A write to a hole gives `wr_en_o`=0 and `wr_drop_o`=1.
- R8: The pointer resets to 00h. A write that resolves to 004h loads `wdata_i` into it, and the new value shows on `ptr_o` and is used for indirect access from the next cycle on. No other access changes the pointer.
- R9: While `req_i`=0, the outputs `valid_o`, `rd_zero_o`, `wr_en_o`, `wr_drop_o` and `phys_addr_o` are all 0.
- R10: A write to a valid location gives `wr_en_o`=1 and `valid_o`=1, at the mapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access in this cycle |
| we_i | input | 1 | Access is a write |
| ofs_i | input | 7 | Direct offset from the instruction |
| bank_i | input | 2 | Direct bank select |
| ind_bank_i | input | 1 | Bank bit for indirect access |
| wdata_i | input | 8 | Write data (used to load the pointer) |
| phys_addr_o | output | 9 | Resolved physical location |
| valid_o | output | 1 | Access hits real storage |
| rd_zero_o | output | 1 | Access returns zero |
| wr_en_o | output | 1 | Write allowed to storage |
| wr_drop_o | output | 1 | Write to a hole was discarded |
| ptr_o | output | 8 | Current pointer register value |

## Verification
The pointer is the only state in this block. A wrong pointer value shows on `ptr_o` in the cycle after the faulty load. It also shows on `phys_addr_o` and the flags of the next offset-00h access, which the pointer sweep makes in the very next cycle for each of the 256 pointer values and both bank bits. Folding and hole errors need no state to appear, so the full direct sweep of all four banks exposes them in the same cycle as the access.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int OFS_W    = 7;
  localparam int BANK_W   = 2;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = OFS_W + BANK_W;
  localparam int NUM_CORE = 5;

  localparam logic [OFS_W-1:0] COMMON_BASE = 7'h70;
  localparam logic [ADDR_W-1:0] PTR_LOC    = 9'h004;
  localparam logic [OFS_W-1:0] CORE_OFS [NUM_CORE] = '{7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B};

  function automatic logic is_hole(input logic [ADDR_W-1:0] a);
    case (a) inside
      9'h00D, [9'h018:9'h01D],
      9'h08D, [9'h08F:9'h09E],
      9'h105, 9'h109, 9'h10C,
      9'h185, 9'h189, [9'h18C:9'h19F]: return 1'b1;
      default:                         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bank_map_select.sv
module bank_map_select
  import bank_map_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int BW = BANK_W,
  parameter int DW = DATA_W,
  localparam int AW = OW + BW
) (
  input  logic [OW-1:0] ofs_i,
  input  logic [BW-1:0] bank_i,
  input  logic          ind_bank_i,
  input  logic [DW-1:0] ptr_i,
  output logic [AW-1:0] eff_o,
  output logic          null_o
);
  logic use_ptr;
  assign use_ptr = (ofs_i == '0);
  assign eff_o   = use_ptr ? {ind_bank_i, ptr_i} : {bank_i, ofs_i};
  // alias seen through the pointer resolves to nothing
  assign null_o  = (eff_o[OW-1:0] == '0);
endmodule

// File: rtl/bank_map_fold.sv
module bank_map_fold
  import bank_map_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int BW = BANK_W,
  localparam int AW = OW + BW
) (
  input  logic [AW-1:0] eff_i,
  output logic [AW-1:0] loc_o,
  output logic          hole_o
);
  logic [OW-1:0]       ofs;
  logic [NUM_CORE-1:0] core_hit;
  logic                shared;

  assign ofs = eff_i[OW-1:0];

  for (genvar g = 0; g < NUM_CORE; g++) begin : g_core
    assign core_hit[g] = (ofs == CORE_OFS[g]);
  end

  assign shared = (ofs >= COMMON_BASE) || (|core_hit);
  assign hole_o = !shared && is_hole(eff_i);
  assign loc_o  = shared ? {{BW{1'b0}}, ofs} : eff_i;
endmodule

// File: rtl/bank_map_ptr.sv
module bank_map_ptr
  import bank_map_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= data_i;
  end

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ptr_o));
  assert_ptr_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_o == $past(data_i));
endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
  import bank_map_pkg::*;
#(
  parameter int OW = OFS_W,
  parameter int BW = BANK_W,
  parameter int DW = DATA_W,
  localparam int AW = OW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [BW-1:0] bank_i,
  input  logic          ind_bank_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] phys_addr_o,
  output logic          valid_o,
  output logic          rd_zero_o,
  output logic          wr_en_o,
  output logic          wr_drop_o,
  output logic [DW-1:0] ptr_o
);
  logic [AW-1:0] eff_w, loc_w;
  logic          null_w, hole_w, hit, ptr_load;

  bank_map_select #(.OW(OW), .BW(BW), .DW(DW)) u_sel (
    .ofs_i(ofs_i), .bank_i(bank_i), .ind_bank_i(ind_bank_i), .ptr_i(ptr_o),
    .eff_o(eff_w), .null_o(null_w)
  );

  bank_map_fold #(.OW(OW), .BW(BW)) u_fold (
    .eff_i(eff_w), .loc_o(loc_w), .hole_o(hole_w)
  );

  assign hit         = req_i && !null_w && !hole_w;
  assign valid_o     = hit;
  assign rd_zero_o   = req_i && !hit;
  assign wr_en_o     = hit && we_i;
  assign wr_drop_o   = req_i && we_i && hole_w;
  assign phys_addr_o = hit ? loc_w : '0;
  assign ptr_load    = wr_en_o && (loc_w == PTR_LOC);

  bank_map_ptr #(.DW(DW)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ptr_load), .data_i(wdata_i), .ptr_o(ptr_o)
  );

  assert_alias_null_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ofs_i == '0 && ptr_o[OW-1:0] == '0) |-> (rd_zero_o && !wr_en_o && !wr_drop_o));
  assert_common_fold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ofs_i >= COMMON_BASE) |-> (valid_o && phys_addr_o == {{BW{1'b0}}, ofs_i}));
  assert_hole_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (!wr_en_o && !valid_o && rd_zero_o));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(valid_o || rd_zero_o || wr_en_o || wr_drop_o));
endmodule

// File: tb/bank_map_top_test.sv
`timescale 1ns/1ps
module bank_map_top_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, ind_bank_i = 1'b0;
  logic [6:0] ofs_i = '0;
  logic [1:0] bank_i = '0;
  logic [7:0] wdata_i = '0;
  logic [8:0] phys_addr_o;
  logic       valid_o, rd_zero_o, wr_en_o, wr_drop_o;
  logic [7:0] ptr_o;

  always #10 clk = ~clk;

  bank_map_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .ofs_i(ofs_i),
    .bank_i(bank_i), .ind_bank_i(ind_bank_i), .wdata_i(wdata_i),
    .phys_addr_o(phys_addr_o), .valid_o(valid_o), .rd_zero_o(rd_zero_o),
    .wr_en_o(wr_en_o), .wr_drop_o(wr_drop_o), .ptr_o(ptr_o)
  );

  typedef struct {
    logic [8:0] phys;
    logic       valid, rdz, wen, wdrop;
    logic [7:0] ptr;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0, errors = 0;
  logic [7:0] mptr = 8'h00;
  bit         done = 0;

  function automatic logic ref_hole(input logic [8:0] a);
    return (a == 9'h00D) || (a >= 9'h018 && a <= 9'h01D) || (a == 9'h08D) ||
           (a >= 9'h08F && a <= 9'h09E) || (a == 9'h105) || (a == 9'h109) ||
           (a == 9'h10C) || (a == 9'h185) || (a == 9'h189) ||
           (a >= 9'h18C && a <= 9'h19F);
  endfunction

  function automatic exp_t model(input logic r, input logic w, input logic [6:0] o,
                                 input logic [1:0] b, input logic ib, input logic [7:0] p);
    exp_t e;
    logic [8:0] a;
    logic [6:0] lo;
    e.ptr = p; e.phys = '0; e.valid = 0; e.rdz = 0; e.wen = 0; e.wdrop = 0; e.tag = "R9";
    if (!r) return e;
    a  = (o == 7'h00) ? {ib, p} : {b, o};
    lo = a[6:0];
    if (lo == 7'h00) begin
      e.rdz = 1; e.tag = "R3"; return e;
    end
    if (lo >= 7'h70) begin
      e.phys = {2'b00, lo}; e.tag = "R4";
    end else if (lo == 7'h02 || lo == 7'h03 || lo == 7'h04 || lo == 7'h0A || lo == 7'h0B) begin
      e.phys = {2'b00, lo}; e.tag = "R5";
    end else if (ref_hole(a)) begin
      e.rdz = 1; e.wdrop = w; e.tag = w ? "R7" : "R6"; return e;
    end else begin
      e.phys = a; e.tag = (o == 7'h00) ? "R2" : (w ? "R10" : "R1");
    end
    e.valid = 1; e.wen = w;
    return e;
  endfunction

  task automatic drive(input logic r, input logic w, input logic [6:0] o, input logic [1:0] b,
                       input logic ib, input logic [7:0] d, input string tag);
    exp_t e;
    @(posedge clk); #2;
    req_i = r; we_i = w; ofs_i = o; bank_i = b; ind_bank_i = ib; wdata_i = d;
    e = model(r, w, o, b, ib, mptr);
    if (tag != "") e.tag = tag;
    sb.push_back(e);
    if (e.wen && e.phys == 9'h004) mptr = d;
  endtask

  // monitor: compare at the falling edge, away from the register update
  initial forever begin
    exp_t e;
    @(negedge clk);
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (phys_addr_o !== e.phys || valid_o !== e.valid || rd_zero_o !== e.rdz ||
          wr_en_o !== e.wen || wr_drop_o !== e.wdrop || ptr_o !== e.ptr) begin
        errors++;
        $display("FAIL %s: got phys=%h v=%b z=%b we=%b drop=%b ptr=%h exp phys=%h v=%b z=%b we=%b drop=%b ptr=%h",
                 e.tag, phys_addr_o, valid_o, rd_zero_o, wr_en_o, wr_drop_o, ptr_o,
                 e.phys, e.valid, e.rdz, e.wen, e.wdrop, e.ptr);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #15;
    checks++; // reset state, R8 and R9
    if (ptr_o !== 8'h00 || valid_o !== 1'b0 || wr_en_o !== 1'b0 || phys_addr_o !== 9'h000) begin
      errors++;
      $display("FAIL R8 reset: got ptr=%h v=%b we=%b phys=%h exp ptr=00 v=0 we=0 phys=000",
               ptr_o, valid_o, wr_en_o, phys_addr_o);
    end
    #20 rst_ni = 1'b1;

    drive(0, 1, 7'h25, 2'd2, 0, 8'hAA, "R9");
    drive(1, 0, 7'h25, 2'd2, 0, 8'h00, "R1");
    drive(1, 0, 7'h6F, 2'd3, 0, 8'h00, "R1");
    drive(1, 1, 7'h20, 2'd2, 0, 8'h5A, "R10");
    // R3: alias via reset pointer, read and write
    drive(1, 0, 7'h00, 2'd1, 0, 8'h00, "R3");
    drive(1, 1, 7'h00, 2'd1, 1, 8'h33, "R3");
    // R8: load pointer through the bank 1 mirror, then R2 indirect use
    drive(1, 1, 7'h04, 2'd1, 0, 8'h25, "R8");
    drive(1, 0, 7'h00, 2'd3, 1, 8'h00, "R2");
    drive(1, 0, 7'h00, 2'd0, 0, 8'h00, "R2");
    drive(1, 1, 7'h04, 2'd0, 0, 8'h80, "R8");
    drive(1, 0, 7'h00, 2'd2, 1, 8'h00, "R3");
    drive(1, 1, 7'h04, 2'd3, 0, 8'hF3, "R8");
    drive(1, 0, 7'h00, 2'd0, 0, 8'h00, "R4");
    drive(1, 0, 7'h75, 2'd3, 0, 8'h00, "R4");
    drive(1, 0, 7'h70, 2'd1, 0, 8'h00, "R4");
    drive(1, 0, 7'h0B, 2'd2, 0, 8'h00, "R5");
    drive(1, 0, 7'h03, 2'd1, 0, 8'h00, "R5");
    drive(1, 0, 7'h0D, 2'd0, 0, 8'h00, "R6");
    drive(1, 0, 7'h0F, 2'd1, 0, 8'h00, "R6");
    drive(1, 0, 7'h1F, 2'd1, 0, 8'h00, "R1");
    drive(1, 0, 7'h1F, 2'd3, 0, 8'h00, "R6");
    drive(1, 0, 7'h1E, 2'd0, 0, 8'h00, "R1");
    drive(1, 1, 7'h09, 2'd2, 0, 8'h11, "R7");
    drive(1, 1, 7'h04, 2'd2, 0, 8'h8C, "R8");
    drive(1, 1, 7'h00, 2'd0, 1, 8'h22, "R7");
    drive(0, 1, 7'h04, 2'd0, 0, 8'h77, "R9");
    drive(1, 0, 7'h02, 2'd0, 0, 8'h00, "R8");

    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 128; o++)
        drive(1, 0, 7'(o), 2'(b), 1'(b & 1), 8'h00, "");

    for (int p = 0; p < 256; p++)
      for (int ib = 0; ib < 2; ib++) begin
        drive(1, 1, 7'h04, 2'(p & 3), 0, 8'(p), "");
        drive(1, 0, 7'h00, 2'(3 - (p & 3)), 1'(ib), 8'h00, "");
      end

    @(posedge clk); #2 req_i = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule